// File: doc/BRIEF.md
# Output Phase Slew Limiter for a Clock-Recovery Loop

This block sits between a digital clock-recovery loop and the oscillator it steers. When the loop changes its input reference or its operating mode, the phase of the loop's new state can differ from the old one. Applying that difference at once would make the output frequency jump. The block takes the requested correction, bounds it to ±20 ns, and holds it as a pending phase. It then pays the pending phase out in small signed adjustments, at most one per 125 µs frame. The size of each adjustment is set by a skew setting.

Phase is expressed in units of 1/16 ns (0.0625 ns). The skew setting uses the same unit per frame. The largest usable rate is 246 units, which is 15.375 ns per frame and about 123 ppm. A frame timer counts `FRAME_CYCLES` clocks per frame, which is 12,500 at 100 MHz.

The control is a two-state machine. In IDLE the pending phase is zero. In SLEW the pending phase is nonzero. The transitions are:
- LOAD: IDLE to SLEW, on a strobe that carries a nonzero correction.
- RELOAD: SLEW to SLEW, on a strobe that carries a nonzero correction.
- CANCEL: any state to IDLE, on a strobe that carries a zero correction.
- FINISH: SLEW to IDLE, on the frame tick whose adjustment empties the pending phase.
- HOLD: SLEW to SLEW, on a frame tick that leaves phase pending, or while the skew is zero.

Top module: `phase_slew_limiter`

## Requirements
- R1: After reset, `adj_valid_o`, `done_o` and `busy_o` are 0 and `adj_o` is 0.
- R2: Adjustments are only emitted on frame ticks, which recur every `FRAME_CYCLES` clocks. Successive `adj_valid_o` pulses of one re-arrangement are exactly `FRAME_CYCLES` clocks apart, and each pulse is one cycle wide.
- R3: On a strobe (`rearr_i` = 1), `corr_i` is saturated to the range -320..+320 units (±20 ns) and becomes the pending phase. The adjustments that follow sum exactly to the saturated value.
- R4: A strobe that arrives while phase is still pending discards the old remainder. Only the new correction is paid out.
- R5: Each adjustment equals min(effective skew, |pending|), carries the sign of the pending phase, and is subtracted from the pending phase.
- R6: A `skew_i` value above 246 is treated as 246. No adjustment magnitude ever exceeds 246 units.
- R7: While `skew_i` is 0, frame ticks emit nothing, the pending phase is kept, and `busy_o` stays high. Payout resumes once the skew is made nonzero.
- R8: `busy_o` is 1 exactly while phase is pending. `done_o` is a one-cycle pulse that coincides with the adjustment that empties the pending phase.
- R9: When a strobe and a frame tick fall in the same cycle, the strobe wins. The new correction is loaded and no adjustment is emitted for that frame.
- R10: A strobe whose correction is 0 clears any pending phase, drops `busy_o` on the next cycle, and emits neither an adjustment nor a `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rearr_i | input | 1 | Re-arrangement strobe, one cycle |
| corr_i | input | CORR_W (16) | Requested phase correction, signed, 1/16 ns units |
| skew_i | input | SKEW_W (8) | Slew rate limit per frame, 1/16 ns units |
| adj_valid_o | output | 1 | Adjustment valid, one cycle per frame at most |
| adj_o | output | PH_W (12) | Signed phase adjustment, 1/16 ns units |
| busy_o | output | 1 | Phase still pending |
| done_o | output | 1 | Final adjustment of a re-arrangement |

## Verification
A re-arrangement strobe and a frame tick can land in the same cycle. Loading the new correction and paying out the old one then compete for the pending register.

The bench first learns the frame phase from an observed adjustment pulse. It then counts exactly `FRAME_CYCLES` clocks and raises the strobe so that it is sampled on the edge that ends the next tick cycle. It judges the outcome three ways:
- No pulse appears for that frame.
- `busy_o` stays high.
- The following frames pay out only the new correction, at the expected spacing.

// File: rtl/psl_pkg.sv
package psl_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SLEW = 1'b1
    } psl_state_e;
endpackage

// File: rtl/psl_frame_timer.sv
module psl_frame_timer #(
    parameter int CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/psl_step_clamp.sv
module psl_step_clamp #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12,
    parameter int LIMIT = 320
) (
    input  logic signed [IN_W-1:0]  val_i,
    output logic signed [OUT_W-1:0] val_o
);
    localparam logic signed [IN_W-1:0] HI = IN_W'(LIMIT);
    localparam logic signed [IN_W-1:0] LO = -HI;

    logic signed [IN_W-1:0] sat;

    always_comb begin
        if (val_i > HI)      sat = HI;
        else if (val_i < LO) sat = LO;
        else                 sat = val_i;
        val_o = OUT_W'(sat);
    end

    // R3
    clamp_range_chk: assert final ((val_o <= OUT_W'(LIMIT)) && (val_o >= -OUT_W'(LIMIT)));
endmodule

// File: rtl/psl_slew_fsm.sv
module psl_slew_fsm
    import psl_pkg::*;
#(
    parameter int PH_W     = 12,
    parameter int SKEW_W   = 8,
    parameter int MAX_STEP = 320,
    parameter int MAX_RATE = 246
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic                   load_i,
    input  logic signed [PH_W-1:0] load_val_i,
    input  logic [SKEW_W-1:0]      skew_i,
    output logic                   adj_valid_o,
    output logic signed [PH_W-1:0] adj_o,
    output logic                   busy_o,
    output logic                   done_o
);
    localparam logic [PH_W-1:0] RATE_LIM = PH_W'(MAX_RATE);
    localparam logic [PH_W-1:0] STEP_LIM = PH_W'(MAX_STEP);

    psl_state_e             state_q, state_d;
    logic signed [PH_W-1:0] pend_q, pend_d;
    logic [PH_W-1:0]        mag, skew_w, eff_rate, step_mag;
    logic signed [PH_W-1:0] step_s;
    logic                   emit;

    always_comb begin
        mag      = pend_q[PH_W-1] ? -pend_q : pend_q;
        skew_w   = PH_W'(skew_i);
        eff_rate = (skew_w > RATE_LIM) ? RATE_LIM : skew_w;
        step_mag = (eff_rate < mag) ? eff_rate : mag;
        step_s   = pend_q[PH_W-1] ? -$signed(step_mag) : $signed(step_mag);
    end

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        emit    = 1'b0;
        if (load_i) begin
            pend_d  = load_val_i;
            state_d = (load_val_i != '0) ? ST_SLEW : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_SLEW: begin
                    if (tick_i && (step_mag != '0)) begin
                        emit   = 1'b1;
                        pend_d = pend_q - step_s;
                        if (step_mag == mag) state_d = ST_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adj_valid_o <= 1'b0;
            adj_o       <= '0;
            done_o      <= 1'b0;
        end else begin
            adj_valid_o <= emit;
            adj_o       <= emit ? step_s : '0;
            done_o      <= emit && (state_d == ST_IDLE);
        end
    end

    assign busy_o = (state_q == ST_SLEW);

    logic [PH_W-1:0] adj_mag;
    assign adj_mag = adj_o[PH_W-1] ? -adj_o : adj_o;

    // R3
    pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mag <= STEP_LIM);
    // R6
    step_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adj_valid_o |-> (adj_mag <= RATE_LIM));
    // R8
    done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (adj_valid_o && !busy_o));
    // R8
    busy_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (pend_q != '0));
    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && tick_i && (skew_i == '0) && !load_i) |=> (!adj_valid_o && $stable(pend_q)));
    // R9
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !adj_valid_o);
endmodule

// File: rtl/phase_slew_limiter.sv
module phase_slew_limiter #(
    parameter int FRAME_CYCLES = 12500,
    parameter int CORR_W       = 16,
    parameter int PH_W         = 12,
    parameter int SKEW_W       = 8,
    parameter int MAX_STEP     = 320,
    parameter int MAX_RATE     = 246
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rearr_i,
    input  logic signed [CORR_W-1:0] corr_i,
    input  logic [SKEW_W-1:0]        skew_i,
    output logic                     adj_valid_o,
    output logic signed [PH_W-1:0]   adj_o,
    output logic                     busy_o,
    output logic                     done_o
);
    logic                   tick;
    logic signed [PH_W-1:0] corr_sat;

    psl_frame_timer #(.CYCLES(FRAME_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    psl_step_clamp #(.IN_W(CORR_W), .OUT_W(PH_W), .LIMIT(MAX_STEP)) u_clamp (
        .val_i (corr_i),
        .val_o (corr_sat)
    );

    psl_slew_fsm #(
        .PH_W     (PH_W),
        .SKEW_W   (SKEW_W),
        .MAX_STEP (MAX_STEP),
        .MAX_RATE (MAX_RATE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .load_i      (rearr_i),
        .load_val_i  (corr_sat),
        .skew_i      (skew_i),
        .adj_valid_o (adj_valid_o),
        .adj_o       (adj_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    // R10
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rearr_i && (corr_i == '0)) |=> (!busy_o && !done_o));
endmodule

// File: tb/phase_slew_limiter_tb.sv
module phase_slew_limiter_tb;
    localparam int N    = 16;
    localparam int PH_W = 12;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    rearr_i = 1'b0;
    logic signed [15:0]      corr_i = '0;
    logic [7:0]              skew_i = '0;
    logic                    adj_valid_o;
    logic signed [PH_W-1:0]  adj_o;
    logic                    busy_o;
    logic                    done_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    phase_slew_limiter #(.FRAME_CYCLES(N)) u_dut (
        .clk (clk), .rst_n (rst_n), .rearr_i (rearr_i), .corr_i (corr_i),
        .skew_i (skew_i), .adj_valid_o (adj_valid_o), .adj_o (adj_o),
        .busy_o (busy_o), .done_o (done_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobe(input int v);
        rearr_i = 1'b1;
        corr_i  = 16'(v);
        @(negedge clk);
        rearr_i = 1'b0;
    endtask

    task automatic wait_adj(output bit got);
        got = 1'b0;
        for (int i = 0; i < 3 * N; i++) begin
            @(negedge clk);
            if (adj_valid_o) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic expect_steps(input int pend_in, input int eff, input string req);
        int pend;
        int prev;
        pend = pend_in;
        prev = -1;
        while (pend != 0) begin
            int mag;
            int st;
            bit got;
            mag = (pend < 0) ? -pend : pend;
            st  = (eff < mag) ? eff : mag;
            if (pend < 0) st = -st;
            wait_adj(got);
            check_eq({req, " pulse"}, int'(got), 1);
            if (!got) return;
            pend -= st;
            check_eq({req, " step"}, int'(adj_o), st);
            check_eq({req, " R8 done"}, int'(done_o), int'(pend == 0));
            check_eq({req, " R8 busy"}, int'(busy_o), int'(pend != 0));
            if (prev >= 0) check_eq({req, " R2 spacing"}, cyc - prev, N);
            prev = cyc;
            @(negedge clk);
            check_eq({req, " R2 width"}, int'(adj_valid_o), 0);
        end
    endtask

    task automatic quiet(input int cycles, input int busy_exp, input string req);
        int seen;
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (adj_valid_o || done_o) seen++;
        end
        check_eq({req, " no output"}, seen, 0);
        check_eq({req, " busy"}, int'(busy_o), busy_exp);
    endtask

    task automatic t_reset();
        check_eq("R1 valid", int'(adj_valid_o), 0);
        check_eq("R1 done", int'(done_o), 0);
        check_eq("R1 busy", int'(busy_o), 0);
        check_eq("R1 adj", int'(adj_o), 0);
    endtask

    task automatic t_basic();
        skew_i = 8'd40;
        strobe(100);
        check_eq("R8 busy after load", int'(busy_o), 1);
        expect_steps(100, 40, "R5");
    endtask

    task automatic t_clamp_neg();
        skew_i = 8'd255;
        strobe(-1000);
        expect_steps(-320, 246, "R3 R6");
    endtask

    task automatic t_clamp_pos();
        skew_i = 8'd100;
        strobe(5000);
        expect_steps(320, 100, "R3");
    endtask

    task automatic t_freeze();
        skew_i = 8'd0;
        strobe(50);
        quiet(3 * N, 1, "R7");
        skew_i = 8'd16;
        expect_steps(50, 16, "R7");
    endtask

    task automatic t_discard();
        bit got;
        skew_i = 8'd10;
        strobe(200);
        wait_adj(got);
        check_eq("R4 first", int'(adj_o), 10);
        strobe(-30);
        expect_steps(-30, 10, "R4");
        quiet(2 * N, 0, "R4 after");
    endtask

    task automatic t_cancel();
        skew_i = 8'd10;
        strobe(100);
        strobe(0);
        check_eq("R10 busy drop", int'(busy_o), 0);
        quiet(3 * N, 0, "R10");
    endtask

    task automatic t_collide();
        bit got;
        skew_i = 8'd50;
        strobe(300);
        wait_adj(got);
        check_eq("R9 first", int'(adj_o), 50);
        repeat (N - 1) @(negedge clk);
        strobe(60);
        check_eq("R9 no pulse", int'(adj_valid_o), 0);
        check_eq("R9 busy", int'(busy_o), 1);
        expect_steps(60, 50, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_clamp_neg();
        t_clamp_pos();
        t_freeze();
        t_discard();
        t_cancel();
        t_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule